// File: doc/BRIEF.md
# Key-Locked Paged Watchdog Configuration Block

This block holds a countdown watchdog behind a small configuration space that software reaches through two byte-wide ports. An index port chooses a register and a data port reads or writes it. The space is guarded. Data writes take effect only after an unlock key has been written twice in a row to the index port. A separate key on the index port closes the space again. While the space is open, a page register chooses which register set appears. The watchdog registers appear on one page only.

The watchdog page holds four things: an enable bit, a choice of count unit (seconds or minutes), a byte-wide countdown value, and two options that let keyboard or mouse activity restart the count. The time base comes from two tick-enable inputs, one pulse per second and one pulse per minute. Keyboard and mouse events arrive as single-cycle pulses. When the count reaches zero while the watchdog is enabled, the block raises a reset request. Software keeps the system alive by rewriting the countdown value before it runs out.

Top module: `wdt_cfg_regs`

## Requirements
- R1: While the space is not open, data-port writes change nothing and `rd_data` reads 0xFF.
- R2: The space opens only after index-port writes of 0x87 on two consecutive index writes. Any other value written between them restarts the sequence.
- R3: While the space is open, an index-port write of 0xAA closes it. The next read then returns 0xFF.
- R4: Index 0x07 is the page register and always reads back its value. Indexes 0x30, 0xF5, 0xF6 and 0xF7 reach the watchdog only while the page holds 8. Every other index, and these four on any other page, read 0x00.
- R5: After reset the block is in this state: closed, page 0, enable 0, register 0xF5 = 0x08 (minutes), countdown 5 (with a reload value of 5), and register 0xF7 = 0x00.
- R6: Bit 0 of register 0x30 is the enable bit (1 = running). Bits 7:1 read as 0.
- R7: Bit 3 of register 0xF5 picks the tick input: 0 picks `tick_sec` and 1 picks `tick_min`. Pulses on the other input have no effect. The other bits of 0xF5 are plain storage.
- R8: A write to register 0xF6 loads the countdown and stores the value as the reload value. Reads of 0xF6 return the current count.
- R9: While the watchdog is enabled, each pulse of the selected tick lowers a nonzero count by one. The count holds at zero, and it also holds whenever the watchdog is disabled.
- R10: `wdt_rst_req` is high exactly when the watchdog is enabled and the count is zero.
- R11: Bit 6 of register 0xF7 lets a `kbd_evt` pulse restore the count to the reload value. Bit 7 does the same for `mouse_evt`. When a bit is cleared, its event has no effect. The other bits of 0xF7 are plain storage.
- R12: When events coincide in one cycle, a 0xF6 write wins over an activity reload, and an activity reload wins over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_sel | input | 1 | Write target: 0 = index port, 1 = data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Value of the register that the current index selects |
| tick_sec | input | 1 | One-cycle pulse once per second |
| tick_min | input | 1 | One-cycle pulse once per minute |
| kbd_evt | input | 1 | One-cycle pulse on keyboard activity |
| mouse_evt | input | 1 | One-cycle pulse on mouse activity |
| wdt_rst_req | output | 1 | Timeout reset request |

## Verification
The countdown register has three possible writers: a software write to 0xF6, an activity reload, and a tick decrement. Two of them often land in the same cycle. The common case is a keepalive write arriving on the same edge as a tick. A keyboard or mouse pulse can also coincide with a tick. The bench forces each of these pairings on purpose with directed cycles. Random traffic then produces many more of them. A bench model that applies the stated priority judges every result, through the count read back from 0xF6 and through the reset request.

// File: rtl/wdt_cfg_pkg.sv
package wdt_cfg_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] KEY_OPEN   = 8'h87;
  localparam logic [DW-1:0] KEY_CLOSE  = 8'hAA;
  localparam logic [DW-1:0] IDX_PAGE   = 8'h07;
  localparam logic [DW-1:0] IDX_ENABLE = 8'h30;
  localparam logic [DW-1:0] IDX_UNIT   = 8'hF5;
  localparam logic [DW-1:0] IDX_COUNT  = 8'hF6;
  localparam logic [DW-1:0] IDX_WAKE   = 8'hF7;
  localparam logic [DW-1:0] WDT_PAGE   = 8'h08;

  localparam int UNIT_BIT  = 3;
  localparam int KBD_BIT   = 6;
  localparam int MOUSE_BIT = 7;

  typedef enum logic [1:0] {
    GATE_CLOSED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_state_t;
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate
  import wdt_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_we,
  input  logic [DW-1:0] wr_data,
  output logic          is_open,
  output logic [DW-1:0] idx_q
);
  gate_state_t st_q, st_d;
  logic [DW-1:0] idx_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    if (idx_we) begin
      unique case (st_q)
        GATE_CLOSED: st_d = (wr_data == KEY_OPEN) ? GATE_HALF : GATE_CLOSED;
        GATE_HALF:   st_d = (wr_data == KEY_OPEN) ? GATE_OPEN : GATE_CLOSED;
        GATE_OPEN: begin
          idx_d = wr_data;
          if (wr_data == KEY_CLOSE) st_d = GATE_CLOSED;
        end
        default:     st_d = GATE_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GATE_CLOSED;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign is_open = (st_q == GATE_OPEN);

  // R2
  half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_q) == GATE_CLOSED |-> st_q != GATE_OPEN);

  // R3
  close_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_open && idx_we && wr_data == KEY_CLOSE) |=> !is_open);
endmodule

// File: rtl/wdt_page_regs.sv
module wdt_page_regs
  import wdt_cfg_pkg::*;
#(
  parameter logic [DW-1:0] UNIT_RST = 8'h08,
  parameter logic [DW-1:0] WAKE_RST = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_open,
  input  logic [DW-1:0] idx_q,
  input  logic          dat_we,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] cnt_q,
  output logic          wdt_en,
  output logic          unit_min,
  output logic          kbd_ok,
  output logic          mouse_ok,
  output logic          cnt_load,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] page_q, page_d;
  logic [DW-1:0] unit_q, unit_d;
  logic [DW-1:0] wake_q, wake_d;
  logic          en_q, en_d;
  logic          wr_ok, on_page;

  assign wr_ok   = is_open && dat_we;
  assign on_page = (page_q == WDT_PAGE);

  always_comb begin
    page_d = page_q;
    unit_d = unit_q;
    wake_d = wake_q;
    en_d   = en_q;
    if (wr_ok) begin
      if (idx_q == IDX_PAGE) page_d = wr_data;
      else if (on_page) begin
        if (idx_q == IDX_ENABLE) en_d   = wr_data[0];
        if (idx_q == IDX_UNIT)   unit_d = wr_data;
        if (idx_q == IDX_WAKE)   wake_d = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      unit_q <= UNIT_RST;
      wake_q <= WAKE_RST;
      en_q   <= 1'b0;
    end else begin
      page_q <= page_d;
      unit_q <= unit_d;
      wake_q <= wake_d;
      en_q   <= en_d;
    end
  end

  assign cnt_load = wr_ok && on_page && (idx_q == IDX_COUNT);
  assign wdt_en   = en_q;
  assign unit_min = unit_q[UNIT_BIT];
  assign kbd_ok   = wake_q[KBD_BIT];
  assign mouse_ok = wake_q[MOUSE_BIT];

  always_comb begin
    rd_data = '0;
    if (!is_open) rd_data = '1;
    else if (idx_q == IDX_PAGE) rd_data = page_q;
    else if (on_page) begin
      unique case (idx_q)
        IDX_ENABLE: rd_data = {{(DW-1){1'b0}}, en_q};
        IDX_UNIT:   rd_data = unit_q;
        IDX_COUNT:  rd_data = cnt_q;
        IDX_WAKE:   rd_data = wake_q;
        default:    rd_data = '0;
      endcase
    end
  end

  // R1
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_open |=> (page_q == $past(page_q) && en_q == $past(en_q)));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
  import wdt_cfg_pkg::*;
#(
  parameter logic [DW-1:0] CNT_RST = 8'd5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wdt_en,
  input  logic          unit_min,
  input  logic          tick_sec,
  input  logic          tick_min,
  input  logic          kbd_ok,
  input  logic          mouse_ok,
  input  logic          kbd_evt,
  input  logic          mouse_evt,
  input  logic          cnt_load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt_q
);
  logic [DW-1:0] cnt_d, rel_q, rel_d;
  logic          tick, wake, dec;

  assign tick = unit_min ? tick_min : tick_sec;
  assign wake = (kbd_ok && kbd_evt) || (mouse_ok && mouse_evt);
  assign dec  = wdt_en && tick && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (cnt_load) begin
      cnt_d = load_val;
      rel_d = load_val;
    end else if (wake) cnt_d = rel_q;
    else if (dec)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RST;
      rel_q <= CNT_RST;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q == $past(load_val));

  // R9
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_load && !wake && wdt_en && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_load && !wake && !wdt_en) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_cfg_pkg::*;
#(
  parameter logic [7:0] CNT_RST  = 8'd5,
  parameter logic [7:0] UNIT_RST = 8'h08,
  parameter logic [7:0] WAKE_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick_sec,
  input  logic       tick_min,
  input  logic       kbd_evt,
  input  logic       mouse_evt,
  output logic       wdt_rst_req
);
  logic          is_open, wdt_en, unit_min, kbd_ok, mouse_ok, cnt_load;
  logic [DW-1:0] idx_q, cnt_q;

  wdt_key_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_we  (wr_en && !wr_sel),
    .wr_data (wr_data),
    .is_open (is_open),
    .idx_q   (idx_q)
  );

  wdt_page_regs #(.UNIT_RST(UNIT_RST), .WAKE_RST(WAKE_RST)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_open  (is_open),
    .idx_q    (idx_q),
    .dat_we   (wr_en && wr_sel),
    .wr_data  (wr_data),
    .cnt_q    (cnt_q),
    .wdt_en   (wdt_en),
    .unit_min (unit_min),
    .kbd_ok   (kbd_ok),
    .mouse_ok (mouse_ok),
    .cnt_load (cnt_load),
    .rd_data  (rd_data)
  );

  wdt_countdown #(.CNT_RST(CNT_RST)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdt_en    (wdt_en),
    .unit_min  (unit_min),
    .tick_sec  (tick_sec),
    .tick_min  (tick_min),
    .kbd_ok    (kbd_ok),
    .mouse_ok  (mouse_ok),
    .kbd_evt   (kbd_evt),
    .mouse_evt (mouse_evt),
    .cnt_load  (cnt_load),
    .load_val  (wr_data),
    .cnt_q     (cnt_q)
  );

  assign wdt_rst_req = wdt_en && (cnt_q == '0);

  // R10
  req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> wdt_en);

  // R1
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_open |-> rd_data == 8'hFF);
endmodule

// File: tb/sim_wdt_cfg_regs.sv
module sim_wdt_cfg_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       tick_sec, tick_min, kbd_evt, mouse_evt;
  logic       wdt_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  int n_cyc = 0;

  always #5 clk = ~clk;

  wdt_cfg_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_data(rd_data), .tick_sec(tick_sec), .tick_min(tick_min),
    .kbd_evt(kbd_evt), .mouse_evt(mouse_evt), .wdt_rst_req(wdt_rst_req)
  );

  // bench model of the requirements
  int         m_st;
  logic [7:0] m_idx, m_page, m_f5, m_f7, m_cnt, m_rel;
  logic       m_en;

  function automatic logic [7:0] exp_rd();
    if (m_st != 2) return 8'hFF;
    if (m_idx == 8'h07) return m_page;
    if (m_page != 8'h08) return 8'h00;
    case (m_idx)
      8'h30: return {7'b0, m_en};
      8'hF5: return m_f5;
      8'hF6: return m_cnt;
      8'hF7: return m_f7;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_req();
    return m_en && (m_cnt == 8'h00);
  endfunction

  task automatic model_reset();
    m_st = 0; m_idx = 8'h00; m_page = 8'h00; m_en = 1'b0;
    m_f5 = 8'h08; m_f7 = 8'h00; m_cnt = 8'd5; m_rel = 8'd5;
  endtask

  task automatic model_step(input logic we, input logic sel, input logic [7:0] d,
                            input logic ts, input logic tm, input logic kb, input logic ms);
    logic load, wake, tk;
    logic [7:0] ncnt;
    load = we && sel && m_st == 2 && m_page == 8'h08 && m_idx == 8'hF6;
    tk   = m_f5[3] ? tm : ts;
    wake = (kb && m_f7[6]) || (ms && m_f7[7]);
    ncnt = m_cnt;
    if (load) begin ncnt = d; m_rel = d; end
    else if (wake) ncnt = m_rel;
    else if (m_en && tk && m_cnt != 0) ncnt = m_cnt - 8'd1;
    if (we && sel && m_st == 2) begin
      if (m_idx == 8'h07) m_page = d;
      else if (m_page == 8'h08) begin
        if (m_idx == 8'h30) m_en = d[0];
        if (m_idx == 8'hF5) m_f5 = d;
        if (m_idx == 8'hF7) m_f7 = d;
      end
    end
    m_cnt = ncnt;
    if (we && !sel) begin
      case (m_st)
        0: m_st = (d == 8'h87) ? 1 : 0;
        1: m_st = (d == 8'h87) ? 2 : 0;
        default: begin m_idx = d; if (d == 8'hAA) m_st = 0; end
      endcase
    end
  endtask

  // one clock: drive after negedge, edge, settle to next negedge
  task automatic cyc(input logic we, input logic sel, input logic [7:0] d,
                     input logic ts = 0, input logic tm = 0, input logic kb = 0, input logic ms = 0);
    wr_en = we; wr_sel = sel; wr_data = d;
    tick_sec = ts; tick_min = tm; kbd_evt = kb; mouse_evt = ms;
    @(posedge clk);
    model_step(we, sel, d, ts, tm, kb, ms);
    @(negedge clk);
    wr_en = 0; wr_sel = 0; wr_data = 0;
    tick_sec = 0; tick_min = 0; kbd_evt = 0; mouse_evt = 0;
  endtask

  task automatic idx(input logic [7:0] v); cyc(1, 0, v); endtask
  task automatic dat(input logic [7:0] v); cyc(1, 1, v); endtask
  task automatic unlock(); idx(8'h87); idx(8'h87); endtask
  task automatic reg_wr(input logic [7:0] a, input logic [7:0] v); idx(a); dat(v); endtask

  task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic chk_rd(input string tag); chk8(tag, rd_data, exp_rd()); endtask
  task automatic chk_req(input string tag);
    chk8(tag, {7'b0, wdt_rst_req}, {7'b0, exp_req()});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    tick_sec = 0; tick_min = 0; kbd_evt = 0; mouse_evt = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state reads FF while closed
    chk8("R1 closed read", rd_data, 8'hFF);
    chk_req("R10 no request after reset");
    // R1 data writes ignored while closed
    dat(8'h08);
    unlock(); idx(8'h07);
    chk8("R1 page untouched by closed write", rd_data, 8'h00);
    // R5 defaults
    dat(8'h08);
    idx(8'hF5); chk8("R5 unit default", rd_data, 8'h08);
    idx(8'hF6); chk8("R5 count default", rd_data, 8'd5);
    idx(8'hF7); chk8("R5 wake default", rd_data, 8'h00);
    idx(8'h30); chk8("R5 enable default", rd_data, 8'h00);
    // R4 unknown index reads 0, other page hides registers
    idx(8'h12); chk8("R4 unknown index", rd_data, 8'h00);
    reg_wr(8'h07, 8'h03); idx(8'hF6); chk8("R4 wrong page hides count", rd_data, 8'h00);
    idx(8'h07); chk8("R4 page readback", rd_data, 8'h03);
    dat(8'h08);
    // R6 upper enable bits read 0
    reg_wr(8'h30, 8'hFE); chk8("R6 enable bits", rd_data, 8'h00);
    // R3 close key
    idx(8'hAA); chk8("R3 closed after key", rd_data, 8'hFF);
    // R2 broken sequence
    idx(8'h87); idx(8'h07); idx(8'h87); idx(8'h07);
    chk8("R2 interrupted key stays closed", rd_data, 8'hFF);
    unlock(); idx(8'h07); chk8("R2 opened by double key", rd_data, 8'h08);

    // R7 R9 R10: seconds unit, count down to zero
    reg_wr(8'hF5, 8'h00); reg_wr(8'hF6, 8'd2); reg_wr(8'h30, 8'h01);
    idx(8'hF6);
    cyc(0, 0, 0, 0, 1); chk8("R7 minute tick ignored in seconds", rd_data, 8'd2);
    cyc(0, 0, 0, 1, 0); chk8("R9 decrement", rd_data, 8'd1);
    chk_req("R10 not yet");
    cyc(0, 0, 0, 1, 0); chk8("R9 reaches zero", rd_data, 8'd0);
    chk_req("R10 request at zero");
    cyc(0, 0, 0, 1, 0); chk8("R9 holds zero", rd_data, 8'd0);
    // R8 keepalive write
    dat(8'd9); chk8("R8 load", rd_data, 8'd9); chk_req("R10 cleared by reload");
    // R11 keyboard reload
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 1, 0); chk8("R11 kbd disabled no effect", rd_data, 8'd7);
    reg_wr(8'hF7, 8'h40); idx(8'hF6);
    cyc(0, 0, 0, 0, 0, 0, 1); chk8("R11 mouse disabled no effect", rd_data, 8'd7);
    cyc(0, 0, 0, 0, 0, 1, 0); chk8("R11 kbd reload", rd_data, 8'd9);
    // R12 conflicts
    cyc(0, 0, 0, 1, 0, 1, 0); chk8("R12 reload beats tick", rd_data, 8'd9);
    cyc(1, 1, 8'd20, 1, 0, 1, 0); chk8("R12 write beats reload and tick", rd_data, 8'd20);
    // R7 minute unit
    reg_wr(8'hF5, 8'h08); idx(8'hF6);
    cyc(0, 0, 0, 1, 0); chk8("R7 second tick ignored in minutes", rd_data, 8'd20);
    cyc(0, 0, 0, 0, 1); chk8("R7 minute tick counts", rd_data, 8'd19);
    // R9 disabled holds
    reg_wr(8'h30, 8'h00); idx(8'hF6);
    cyc(0, 0, 0, 1, 1); chk8("R9 disabled holds", rd_data, 8'd19);

    // random traffic against model: R8 R9 R10 R11 R12
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] v;
      logic [7:0] pick [8];
      pick = '{8'h87, 8'hAA, 8'h07, 8'h30, 8'hF5, 8'hF6, 8'hF7, 8'h21};
      op = $urandom_range(0, 9);
      v  = 8'($urandom);
      if (op == 0) unlock();
      else if (op <= 3) idx(pick[$urandom_range(0, 7)]);
      else if (op <= 5) begin
        if (m_idx == 8'h07 && $urandom_range(0, 3) != 0) v = 8'h08;
        if (m_idx == 8'hF6) v = 8'($urandom_range(0, 6));
        cyc(1, 1, v, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end else
        cyc(0, 0, 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      chk_rd("R8 R11 R12 random readback");
      chk_req("R10 random request");
    end

    finish_run();
  end
endmodule